// File: doc/BRIEF.md
# PCI Base Address Register Configurator

This block holds the two base address registers of a PCI function. They sit at configuration dword offsets 4 and 5, which are byte offsets 10h and 14h. A 16-bit boot control word is read from an external serial EEPROM. It is presented at reset together with a flag that says whether the EEPROM was blank. The block samples both while reset is high. From them it decides whether each of the two slots is a memory base, an I/O base or absent, and whether the memory base is marked prefetchable.

After reset, configuration software probes each slot. It writes all ones, reads back the size mask, and then programs a base address. The block shows each slot's readback value on its own output. It also returns the value through a registered configuration read port, and drives two decode match signals. The memory match covers a fixed 4 KiB window. The I/O match covers a fixed 256-byte window. Each match is gated by the matching enable bit of the command register.

Top module: `pci_bar_cfg`

## Requirements
- R1: While `rst` is high the block samples `ctrl_word` bit 15 (memory enable), bit 14 (I/O enable) and bit 13 (prefetchable), together with `rom_empty`. Bits 12..0 have no effect. Once `rst` is low, changes on these inputs have no effect until the next reset.
- R2: With both enables set, dword offset 4 is a memory base and dword offset 5 is an I/O base.
- R3: With only the memory enable set, offset 4 is a memory base and offset 5 is unimplemented.
- R4: With only the I/O enable set, offset 4 is an I/O base and offset 5 is unimplemented. With neither enable set, both offsets are unimplemented.
- R5: When `rom_empty` was high at reset, offset 4 is a memory base and offset 5 is an I/O base whatever the control word holds, and the prefetchable bit reads 0.
- R6: In a memory base, bits 11..0 are read-only. Bits 2..0 read 0 and bit 3 reads the configured prefetchable flag. Writing all ones reads back FFFFF000h, or FFFFF008h when the flag is set.
- R7: In an I/O base, bits 7..0 are read-only and read 01h. Writing all ones reads back FFFFFF01h.
- R8: An unimplemented offset ignores writes and reads as zero.
- R9: A write updates only the bytes whose `cfg_be` bit is set (bit n covers data bits 8n+7..8n). With no write, a base readback keeps its value. Both bases read their empty pattern (base 0) after reset.
- R10: `mem_hit` is high exactly when `cmd_mem_en` is high, a memory base exists, and `dec_addr[31:12]` equals the programmed memory base bits 31..12.
- R11: `io_hit` is high exactly when `cmd_io_en` is high, an I/O base exists, and `dec_addr[31:8]` equals the programmed I/O base bits 31..8.
- R12: A cycle with `cfg_rd` high and offset 4 or 5 places that slot's readback (value before any same-cycle write) on `cfg_rdata` one cycle later. Any other offset, or no read, gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; boot configuration is sampled while high |
| ctrl_word | input | 16 | Boot control word from the EEPROM |
| rom_empty | input | 1 | EEPROM held no data |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_off | input | 6 | Configuration dword offset |
| cfg_wdata | input | 32 | Write data |
| cfg_be | input | 4 | Write byte enables |
| cfg_rdata | output | 32 | Registered read data |
| bar0_rdata | output | 32 | Current readback of offset 4 |
| bar1_rdata | output | 32 | Current readback of offset 5 |
| cmd_mem_en | input | 1 | Command register memory space enable |
| cmd_io_en | input | 1 | Command register I/O space enable |
| dec_addr | input | 32 | Address to decode |
| mem_hit | output | 1 | Address falls in the memory window |
| io_hit | output | 1 | Address falls in the I/O window |

## Verification
Every enable combination is run, with and without the prefetchable flag, and also with a blank EEPROM and a full control word. This separates the slot-selection cases from one another and from the blank-EEPROM override. In each run the low control bits carry junk, and the control word is inverted after reset, which shows that both are ignored. All-ones writes expose the read-only masks. Split byte-enable writes show that the lanes are independent. Decode probes pair an address inside the window that differs only in its low bits with one that differs in bit 12 or bit 8, and repeat each probe with the command enable off.

// File: rtl/bar_cfg_pkg.sv
package bar_cfg_pkg;

    localparam int DATA_W      = 32;
    localparam int CW_W        = 16;
    localparam int CW_MEM_BIT  = 15;
    localparam int CW_IO_BIT   = 14;
    localparam int CW_PREF_BIT = 13;
    localparam int NUM_SLOTS   = 2;

    typedef enum logic [1:0] {
        SLOT_NONE = 2'd0,
        SLOT_MEM  = 2'd1,
        SLOT_IO   = 2'd2
    } slot_kind_e;

    typedef struct packed {
        logic mem_en;
        logic io_en;
        logic pref;
        logic empty;
    } boot_cfg_t;

    function automatic slot_kind_e slot_kind(input boot_cfg_t c, input int idx);
        logic want_mem, want_io;
        want_mem = c.empty | c.mem_en;
        want_io  = c.empty | c.io_en;
        if (idx == 0)
            return want_mem ? SLOT_MEM : (want_io ? SLOT_IO : SLOT_NONE);
        return (want_mem && want_io) ? SLOT_IO : SLOT_NONE;
    endfunction

    function automatic logic pref_eff(input boot_cfg_t c);
        return c.pref & c.mem_en & ~c.empty;
    endfunction

endpackage

// File: rtl/bar_boot_latch.sv
module bar_boot_latch
    import bar_cfg_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [CW_W-1:0] ctrl_word,
    input  logic            rom_empty,
    output boot_cfg_t       cfg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.mem_en <= ctrl_word[CW_MEM_BIT];
            cfg.io_en  <= ctrl_word[CW_IO_BIT];
            cfg.pref   <= ctrl_word[CW_PREF_BIT];
            cfg.empty  <= rom_empty;
        end
    end

    // R1: configuration never moves outside reset
    p_cfg_frozen_r1: assert property (@(posedge clk)
        (!rst && $past(!rst)) |-> $stable(cfg));
endmodule

// File: rtl/bar_slot.sv
module bar_slot
    import bar_cfg_pkg::*;
#(
    parameter int MEM_LOG2 = 12,
    parameter int IO_LOG2  = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  slot_kind_e          kind,
    input  logic                pref,
    input  logic                wr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [DATA_W/8-1:0] be,
    output logic [DATA_W-1:0]   rdback
);
    localparam logic [DATA_W-1:0] MEM_MASK = ~((DATA_W'(1) << MEM_LOG2) - DATA_W'(1));
    localparam logic [DATA_W-1:0] IO_MASK  = ~((DATA_W'(1) << IO_LOG2) - DATA_W'(1));
    localparam int NBYTES = DATA_W / 8;

    logic [DATA_W-1:0] base_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
        end else if (wr && kind != SLOT_NONE) begin
            for (int b = 0; b < NBYTES; b++)
                if (be[b]) base_q[8*b +: 8] <= wdata[8*b +: 8];
        end
    end

    always_comb begin
        rdback = '0;
        unique case (kind)
            SLOT_MEM: begin
                rdback    = base_q & MEM_MASK;
                rdback[3] = pref;
            end
            SLOT_IO: begin
                rdback    = base_q & IO_MASK;
                rdback[0] = 1'b1;
            end
            default: rdback = '0;
        endcase
    end

    // R9: without a write the readback holds
    p_hold_without_write_r9: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && !$past(wr)) |-> $stable(rdback));
endmodule

// File: rtl/bar_hit.sv
module bar_hit #(
    parameter int CMP_W = 20
) (
    input  logic             en,
    input  logic [CMP_W-1:0] addr_hi,
    input  logic [CMP_W-1:0] base_hi,
    output logic             hit
);
    assign hit = en && (addr_hi == base_hi);
endmodule

// File: rtl/pci_bar_cfg.sv
module pci_bar_cfg
    import bar_cfg_pkg::*;
#(
    parameter int MEM_LOG2     = 12,
    parameter int IO_LOG2      = 8,
    parameter int OFF_W        = 6,
    parameter int FIRST_BAR_DW = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [15:0]       ctrl_word,
    input  logic              rom_empty,
    input  logic              cfg_wr,
    input  logic              cfg_rd,
    input  logic [OFF_W-1:0]  cfg_off,
    input  logic [31:0]       cfg_wdata,
    input  logic [3:0]        cfg_be,
    output logic [31:0]       cfg_rdata,
    output logic [31:0]       bar0_rdata,
    output logic [31:0]       bar1_rdata,
    input  logic              cmd_mem_en,
    input  logic              cmd_io_en,
    input  logic [31:0]       dec_addr,
    output logic              mem_hit,
    output logic              io_hit
);
    localparam int MEM_CMP_W = DATA_W - MEM_LOG2;
    localparam int IO_CMP_W  = DATA_W - IO_LOG2;

    boot_cfg_t         cfg;
    slot_kind_e        kinds   [NUM_SLOTS];
    logic [DATA_W-1:0] slot_rd [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] slot_sel;
    logic              pref;

    bar_boot_latch u_boot (
        .clk(clk), .rst(rst), .ctrl_word(ctrl_word),
        .rom_empty(rom_empty), .cfg(cfg)
    );

    assign pref = pref_eff(cfg);

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        localparam logic [OFF_W-1:0] MY_OFF = OFF_W'(FIRST_BAR_DW + i);
        assign kinds[i]    = slot_kind(cfg, i);
        assign slot_sel[i] = (cfg_off == MY_OFF);
        bar_slot #(.MEM_LOG2(MEM_LOG2), .IO_LOG2(IO_LOG2)) u_slot (
            .clk(clk), .rst(rst), .kind(kinds[i]), .pref(pref),
            .wr(cfg_wr && slot_sel[i]), .wdata(cfg_wdata), .be(cfg_be),
            .rdback(slot_rd[i])
        );
    end

    assign bar0_rdata = slot_rd[0];
    assign bar1_rdata = slot_rd[1];

    // Find which slot carries each kind of window
    logic              mem_present, io_present;
    logic [DATA_W-1:0] mem_base, io_base;
    always_comb begin
        mem_present = 1'b0;
        io_present  = 1'b0;
        mem_base    = '0;
        io_base     = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (kinds[i] == SLOT_MEM) begin
                mem_present = 1'b1;
                mem_base    = slot_rd[i];
            end
            if (kinds[i] == SLOT_IO) begin
                io_present = 1'b1;
                io_base    = slot_rd[i];
            end
        end
    end

    bar_hit #(.CMP_W(MEM_CMP_W)) u_mem_hit (
        .en(cmd_mem_en && mem_present),
        .addr_hi(dec_addr[DATA_W-1:MEM_LOG2]),
        .base_hi(mem_base[DATA_W-1:MEM_LOG2]),
        .hit(mem_hit)
    );

    bar_hit #(.CMP_W(IO_CMP_W)) u_io_hit (
        .en(cmd_io_en && io_present),
        .addr_hi(dec_addr[DATA_W-1:IO_LOG2]),
        .base_hi(io_base[DATA_W-1:IO_LOG2]),
        .hit(io_hit)
    );

    // Registered configuration read
    logic [DATA_W-1:0] rd_mux;
    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NUM_SLOTS; i++)
            if (slot_sel[i]) rd_mux = slot_rd[i];
    end

    always_ff @(posedge clk) begin
        if (rst)         cfg_rdata <= '0;
        else if (cfg_rd) cfg_rdata <= rd_mux;
        else             cfg_rdata <= '0;
    end

    // R10: memory decode requires the command enable
    p_mem_hit_cmd_r10: assert property (@(posedge clk) disable iff (rst)
        mem_hit |-> cmd_mem_en);
    // R11: I/O decode requires the command enable
    p_io_hit_cmd_r11: assert property (@(posedge clk) disable iff (rst)
        io_hit |-> cmd_io_en);
    // R12: reads of other offsets return zero
    p_other_off_zero_r12: assert property (@(posedge clk) disable iff (rst)
        (cfg_rd && slot_sel == '0) |=> (cfg_rdata == '0));
    // R12: no read strobe, no data
    p_idle_zero_r12: assert property (@(posedge clk) disable iff (rst)
        !cfg_rd |=> (cfg_rdata == '0));
endmodule

// File: tb/tb_pci_bar_cfg.sv
`timescale 1ns/100ps
module tb_pci_bar_cfg;
    logic        clk = 0;
    logic        rst = 1;
    logic [15:0] ctrl_word = 0;
    logic        rom_empty = 0;
    logic        cfg_wr = 0, cfg_rd = 0;
    logic [5:0]  cfg_off = 0;
    logic [31:0] cfg_wdata = 0;
    logic [3:0]  cfg_be = 0;
    logic [31:0] cfg_rdata, bar0_rdata, bar1_rdata;
    logic        cmd_mem_en = 0, cmd_io_en = 0;
    logic [31:0] dec_addr = 0;
    logic        mem_hit, io_hit;

    int checks = 0, errors = 0;
    bit started = 0, done = 0;
    string cur_req = "R9";

    always #2.5 clk = ~clk;

    pci_bar_cfg dut (
        .clk(clk), .rst(rst), .ctrl_word(ctrl_word), .rom_empty(rom_empty),
        .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_off(cfg_off),
        .cfg_wdata(cfg_wdata), .cfg_be(cfg_be), .cfg_rdata(cfg_rdata),
        .bar0_rdata(bar0_rdata), .bar1_rdata(bar1_rdata),
        .cmd_mem_en(cmd_mem_en), .cmd_io_en(cmd_io_en), .dec_addr(dec_addr),
        .mem_hit(mem_hit), .io_hit(io_hit)
    );

    // ---------------- behavioural reference ----------------
    // kinds: 0 none, 1 memory, 2 I/O
    bit m_me, m_ie, m_pr, m_empty;
    logic [31:0] m_b0 = 0, m_b1 = 0, m_rd = 0;

    function automatic int kind_of(int idx);
        bit wm = m_empty || m_me;
        bit wi = m_empty || m_ie;
        if (idx == 0) return wm ? 1 : (wi ? 2 : 0);
        return (wm && wi) ? 2 : 0;
    endfunction

    function automatic logic [31:0] view(int k, logic [31:0] b);
        logic [31:0] v;
        if (k == 1) begin
            v = b & 32'hFFFF_F000;
            v[3] = m_pr && m_me && !m_empty;
        end else if (k == 2) begin
            v = (b & 32'hFFFF_FF00) | 32'h1;
        end else v = 0;
        return v;
    endfunction

    function automatic logic [31:0] merge(logic [31:0] o, logic [31:0] n, logic [3:0] e);
        logic [31:0] r = o;
        for (int b = 0; b < 4; b++) if (e[b]) r[8*b +: 8] = n[8*b +: 8];
        return r;
    endfunction

    always @(posedge clk) begin
        started <= 1;
        if (rst) begin
            m_me <= ctrl_word[15]; m_ie <= ctrl_word[14]; m_pr <= ctrl_word[13];
            m_empty <= rom_empty;
            m_b0 <= 0; m_b1 <= 0; m_rd <= 0;
        end else begin
            if (cfg_wr && cfg_off == 6'd4) m_b0 <= merge(m_b0, cfg_wdata, cfg_be);
            if (cfg_wr && cfg_off == 6'd5) m_b1 <= merge(m_b1, cfg_wdata, cfg_be);
            if (cfg_rd && cfg_off == 6'd4)      m_rd <= view(kind_of(0), m_b0);
            else if (cfg_rd && cfg_off == 6'd5) m_rd <= view(kind_of(1), m_b1);
            else                                m_rd <= 0;
        end
    end

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // compare every cycle, away from the active edge
    always @(negedge clk) if (started && !done) begin
        logic [31:0] e0, e1, eb;
        bit emh, eih;
        e0 = view(kind_of(0), m_b0);
        e1 = view(kind_of(1), m_b1);
        emh = cmd_mem_en && kind_of(0) == 1 && dec_addr[31:12] == e0[31:12];
        eih = cmd_io_en && ((kind_of(0) == 2 && dec_addr[31:8] == e0[31:8]) ||
                            (kind_of(1) == 2 && dec_addr[31:8] == e1[31:8]));
        eb = 0;
        check(cur_req, "bar0", bar0_rdata, e0);
        check(cur_req, "bar1", bar1_rdata, e1);
        check("R12", "cfg_rdata", cfg_rdata, m_rd);
        check("R10", "mem_hit", {31'b0, mem_hit}, {31'b0, emh});
        check("R11", "io_hit", {31'b0, io_hit}, {31'b0, eih});
    end

    // ---------------- stimulus ----------------
    task automatic step();
        @(negedge clk); #1;
        cfg_wr = 0; cfg_rd = 0;
    endtask

    task automatic wr(logic [5:0] off, logic [31:0] d, logic [3:0] e);
        cfg_wr = 1; cfg_off = off; cfg_wdata = d; cfg_be = e;
        @(negedge clk); #1; cfg_wr = 0;
    endtask

    task automatic rd(logic [5:0] off);
        cfg_rd = 1; cfg_off = off;
        @(negedge clk); #1; cfg_rd = 0;
    endtask

    task automatic probe(logic [31:0] a);
        dec_addr = a;
        cmd_mem_en = 1; cmd_io_en = 1; step();
        cmd_mem_en = 0; cmd_io_en = 0; step();
    endtask

    task automatic run_cfg(logic [15:0] cw, bit empty, string req);
        cur_req = req;
        @(negedge clk); #1;
        rst = 1; ctrl_word = cw; rom_empty = empty;
        step(); step();
        rst = 0; step();
        ctrl_word = ~cw; rom_empty = !empty;      // R1: ignored after reset
        rd(6'd4); rd(6'd5); rd(6'd3); step();
        wr(6'd4, 32'hFFFF_FFFF, 4'hF);
        wr(6'd5, 32'hFFFF_FFFF, 4'hF);
        rd(6'd4); rd(6'd5); step();
        cur_req = "R9";
        wr(6'd4, 32'h1234_5ABC, 4'b1100);
        wr(6'd4, 32'hDEAD_BEEF, 4'b0010);
        wr(6'd5, 32'h0000_C3A7, 4'hF);
        wr(6'd6, 32'hFFFF_FFFF, 4'hF);
        rd(6'd4); rd(6'd5); rd(6'd6); step();
        cur_req = req;
        probe(bar0_rdata);
        probe(bar0_rdata | 32'h0000_00F4);
        probe(bar0_rdata ^ 32'h0000_1000);
        probe(bar1_rdata & 32'hFFFF_FF00 | 32'h0000_0033);
        probe(bar1_rdata ^ 32'h0000_0100);
        probe(32'h0);
    endtask

    initial begin
        // reset state
        step(); step();
        check("R9", "reset bar0", bar0_rdata, 32'h0000_0008 & 32'h0);
        run_cfg(16'hE5A5, 0, "R2");
        // explicit all-ones sizing checks under both enables, prefetchable
        @(negedge clk); #1; rst = 1; ctrl_word = 16'hE000; rom_empty = 0;
        step(); rst = 0; step();
        wr(6'd4, 32'hFFFF_FFFF, 4'hF); wr(6'd5, 32'hFFFF_FFFF, 4'hF);
        check("R6", "mem all-ones", bar0_rdata, 32'hFFFF_F008);
        check("R7", "io all-ones", bar1_rdata, 32'hFFFF_FF01);
        run_cfg(16'hC01F, 0, "R2");
        run_cfg(16'hA3C0, 0, "R3");
        run_cfg(16'h8001, 0, "R3");
        run_cfg(16'h7FFF, 0, "R4");
        run_cfg(16'h1F0F, 0, "R8");
        run_cfg(16'hE000, 1, "R5");
        run_cfg(16'h2000, 1, "R5");
        check("R5", "empty pref", bar0_rdata & 32'h8, 32'h0);
        run_cfg(16'h5555, 0, "R1");
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule